// File: doc/BRIEF.md
# Two-Bus 4-Bit Arithmetic Datapath

This block is a small processing datapath for 4-bit words. It holds a bank of four registers. Two of them are read at once onto a pair of operand buses that feed an adder-based ALU. The ALU result is captured in an accumulator register. It then passes through an end-around rotator and is written back to a chosen destination register. The same register bank is loaded from an external 4-bit port, and any register can be read back out through a combinational read port.

The ALU is a chain of one-bit adder cells. Addition uses the plain carry chain. Subtraction inverts the second operand and injects a carry of one. The four logic functions come from the same cells with the carry chain cut and the incoming carry of every cell forced to a constant. The sum outputs then give XOR or XNOR, and the carry outputs give AND or OR.

The rotator only rotates right and takes one-hot controls. A left rotation by n is requested as a right rotation by 4 - n. Operations and loads both enter through valid/ready handshakes. Both ready outputs drop for the single cycle in which an operation writes back, so an upstream source stalls for exactly that cycle. A source may hold valid high while ready is low. Nothing is taken until ready returns.

Top module: `dp4_core`

## Requirements
- R1: After reset, all four registers read 0, and busy, carry_out and shift_err are 0.
- R2: On a clock edge where ld_valid and ld_ready are both high, register ld_addr takes ld_data. rd_data always shows the register selected by rd_addr, with no clock delay.
- R3: op_ready and ld_ready are both the inverse of busy. busy is high for exactly the one cycle after an operation is accepted. A valid presented while busy is high has no effect.
- R4: op_func 0 (and the unused codes 6 and 7) adds the two operands. The result is the sum modulo 16, and carry_out is bit 4 of the sum.
- R5: op_func 1 subtracts the second operand from the first by adding its two's complement. The result is the difference modulo 16, and carry_out is 1 exactly when the first operand is not below the second.
- R6: op_func 2 gives the bitwise AND and op_func 3 gives the bitwise OR, both taken from the carry outputs of the cells. carry_out is 0.
- R7: op_func 4 gives the bitwise XOR and op_func 5 gives the bitwise XNOR, both taken from the sum outputs of the cells. carry_out is 0.
- R8: op_shift is one-hot. When bit k is the only bit set, the result is rotated right by k places end-around, so bit i of the output is bit (i+k) mod 4 of the input. A right rotation by 1 therefore equals a left rotation by 3.
- R9: When op_shift is not one-hot (zero, or more than one bit set), the result is written unrotated and shift_err is high during the busy cycle. shift_err is low at all other times.
- R10: carry_out updates on the edge that accepts an operation and holds until the next accepted operation. The destination register takes the rotated result on the edge that ends the busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Operation can be accepted |
| op_src_a | input | 2 | First operand register |
| op_src_b | input | 2 | Second operand register |
| op_func | input | 3 | ALU function code |
| op_shift | input | 4 | One-hot right-rotate amount |
| op_dst | input | 2 | Destination register |
| ld_valid | input | 1 | Port load request |
| ld_ready | output | 1 | Port load can be accepted |
| ld_addr | input | 2 | Register to load |
| ld_data | input | 4 | Data from the external port |
| rd_addr | input | 2 | Register to drive out |
| rd_data | output | 4 | Selected register contents |
| busy | output | 1 | Write-back cycle in progress |
| carry_out | output | 1 | Carry of the last accepted operation |
| shift_err | output | 1 | Illegal rotate control in the current write-back |

## Verification
A wrong accumulator or a broken carry cell shows up on rd_data at the destination register one edge after the busy cycle. It also shows up on carry_out already during the busy cycle, so every operation is checked within two cycles of acceptance. A stuck or overlong write-back phase shows as busy or the ready outputs staying low for a second cycle. A stray write appears when a register that should be untouched is read back. The rotator's illegal-control path is visible on shift_err in the busy cycle and on the unrotated value written back.

// File: rtl/dp4_pkg.sv
package dp4_pkg;
  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_XNOR = 3'd5,
    FN_RSV6 = 3'd6,
    FN_RSV7 = 3'd7
  } alu_func_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WB   = 1'b1
  } phase_e;
endpackage

// File: rtl/dp4_regfile.sv
module dp4_regfile #(
  parameter int W     = 4,
  parameter int NREG  = 4,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [W-1:0]        wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [NREG-1:0][W-1:0] mem_q;

  // one flop row per register, written only when addressed
  for (genvar r = 0; r < NREG; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[r] <= '0;
      else if (we && (waddr == AW'(r)))
        mem_q[r] <= wdata;
    end
  end

  // asynchronous read ports
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[raddr[p]];
  end
endmodule

// File: rtl/dp4_alu.sv
module dp4_alu
  import dp4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   func,
  output logic [W-1:0] res,
  output logic         cout
);
  alu_func_e fn;
  logic      is_sub, is_logic, force_c, use_carry;
  logic [W-1:0] bb, h, s, g;
  logic [W:0]   c;

  always_comb begin
    fn        = alu_func_e'(func);
    is_sub    = (fn == FN_SUB);
    is_logic  = (fn == FN_AND) || (fn == FN_OR) || (fn == FN_XOR) || (fn == FN_XNOR);
    force_c   = (fn == FN_OR) || (fn == FN_XNOR);
    use_carry = (fn == FN_AND) || (fn == FN_OR);
  end

  assign bb   = is_sub ? ~b : b;
  assign c[0] = is_sub;

  // chain of one-bit adder cells; logic functions cut the chain
  for (genvar k = 0; k < W; k++) begin : g_cell
    logic cin_k;
    assign cin_k    = is_logic ? force_c : c[k];
    assign h[k]     = a[k] ^ bb[k];
    assign s[k]     = h[k] ^ cin_k;
    assign g[k]     = (a[k] & bb[k]) | (h[k] & cin_k);
    assign c[k+1]   = g[k];
  end

  assign res  = use_carry ? g : s;
  assign cout = is_logic ? 1'b0 : c[W];
endmodule

// File: rtl/dp4_rotator.sv
module dp4_rotator #(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] sel,
  output logic [W-1:0] dout,
  output logic         bad_sel
);
  logic [W-1:0][W-1:0] lane;
  logic [W-1:0]        merged;

  assign bad_sel = (sel == '0) || ((sel & (sel - W'(1))) != '0);

  // one lane per rotate amount, enabled by its own control line
  for (genvar k = 0; k < W; k++) begin : g_amt
    logic [2*W-1:0] dbl;
    assign dbl     = {din, din} >> k;
    assign lane[k] = sel[k] ? dbl[W-1:0] : '0;
  end

  always_comb begin
    merged = '0;
    for (int k = 0; k < W; k++) merged |= lane[k];
  end

  assign dout = bad_sel ? din : merged;
endmodule

// File: rtl/dp4_core.sv
module dp4_core
  import dp4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  output logic       op_ready,
  input  logic [1:0] op_src_a,
  input  logic [1:0] op_src_b,
  input  logic [2:0] op_func,
  input  logic [3:0] op_shift,
  input  logic [1:0] op_dst,
  input  logic       ld_valid,
  output logic       ld_ready,
  input  logic [1:0] ld_addr,
  input  logic [3:0] ld_data,
  input  logic [1:0] rd_addr,
  output logic [3:0] rd_data,
  output logic       busy,
  output logic       carry_out,
  output logic       shift_err
);
  localparam int W    = 4;
  localparam int NREG = 4;
  localparam int AW   = $clog2(NREG);
  localparam int NRD  = 3;

  phase_e        phase_q;
  logic [W-1:0]  acc_q;
  logic          carry_q;
  logic [AW-1:0] dst_q;
  logic [W-1:0]  shc_q;

  logic                  op_take, ld_take, wb;
  logic                  rf_we;
  logic [AW-1:0]         rf_waddr;
  logic [W-1:0]          rf_wdata;
  logic [NRD-1:0][AW-1:0] rf_raddr;
  logic [NRD-1:0][W-1:0]  rf_rdata;
  logic [W-1:0]          alu_res, rot_out;
  logic                  alu_cout, rot_bad;

  assign wb       = (phase_q == ST_WB);
  assign busy     = wb;
  assign op_ready = !wb;
  assign ld_ready = !wb;
  assign op_take  = op_valid && op_ready;
  assign ld_take  = ld_valid && ld_ready;

  assign rf_raddr[0] = op_src_a;
  assign rf_raddr[1] = op_src_b;
  assign rf_raddr[2] = rd_addr;

  // write-back has the write port in its cycle; loads are stalled then
  assign rf_we    = wb || ld_take;
  assign rf_waddr = wb ? dst_q : ld_addr;
  assign rf_wdata = wb ? rot_out : ld_data;

  dp4_regfile #(.W(W), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  dp4_alu #(.W(W)) u_alu (
    .a    (rf_rdata[0]),
    .b    (rf_rdata[1]),
    .func (op_func),
    .res  (alu_res),
    .cout (alu_cout)
  );

  dp4_rotator #(.W(W)) u_rot (
    .din     (acc_q),
    .sel     (shc_q),
    .dout    (rot_out),
    .bad_sel (rot_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      acc_q   <= '0;
      carry_q <= 1'b0;
      dst_q   <= '0;
      shc_q   <= '0;
    end else begin
      phase_q <= op_take ? ST_WB : ST_IDLE;
      if (op_take) begin
        acc_q   <= alu_res;
        carry_q <= alu_cout;
        dst_q   <= op_dst;
        shc_q   <= op_shift;
      end
    end
  end

  assign rd_data   = rf_rdata[2];
  assign carry_out = carry_q;
  assign shift_err = wb && rot_bad;
endmodule

// File: rtl/dp4_core_chk.sv
module dp4_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_ready,
  input logic       ld_valid,
  input logic       ld_ready,
  input logic [1:0] ld_addr,
  input logic [3:0] ld_data,
  input logic [1:0] rd_addr,
  input logic [3:0] rd_data,
  input logic       busy,
  input logic       carry_out,
  input logic       shift_err
);
  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> busy);
  assert_busy_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!op_ready && !ld_ready));
  assert_err_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_err |-> busy);
  assert_carry_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_ready) |=> $stable(carry_out));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (rd_addr != $past(ld_addr) || rd_data == $past(ld_data)));
endmodule

bind dp4_core dp4_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .ld_addr   (ld_addr),
  .ld_data   (ld_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .busy      (busy),
  .carry_out (carry_out),
  .shift_err (shift_err)
);

// File: tb/tb_dp4_core.sv
module tb_dp4_core;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [1:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
  logic [2:0] op_func = '0;
  logic [3:0] op_shift = '0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [1:0] ld_addr = '0;
  logic [3:0] ld_data = '0;
  logic [1:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic       busy, carry_out, shift_err;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [3:0] model [4];

  dp4_core dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_alu(input logic [3:0] a, input logic [3:0] b, input logic [2:0] f);
    case (f)
      3'd1:    exp_alu = {1'b0, a} + {1'b0, ~b} + 5'd1;
      3'd2:    exp_alu = {1'b0, a & b};
      3'd3:    exp_alu = {1'b0, a | b};
      3'd4:    exp_alu = {1'b0, a ^ b};
      3'd5:    exp_alu = {1'b0, ~(a ^ b)};
      default: exp_alu = {1'b0, a} + {1'b0, b};
    endcase
  endfunction

  function automatic logic is_onehot(input logic [3:0] s);
    return (s == 4'd1) || (s == 4'd2) || (s == 4'd4) || (s == 4'd8);
  endfunction

  function automatic logic [3:0] exp_rot(input logic [3:0] d, input logic [3:0] s);
    logic [3:0] r;
    if (!is_onehot(s)) return d;
    r = d;
    for (int k = 0; k < 4; k++)
      if (s[k]) for (int i = 0; i < 4; i++) r[i] = d[(i + k) % 4];
    return r;
  endfunction

  task automatic read_check(input logic [1:0] a, input logic [3:0] exp, input string tag);
    rd_addr = a;
    #1;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic do_load(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    #1 check(ld_ready == 1'b1, "R3 ld_ready idle", ld_ready, 1);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    model[a] = d;
    read_check(a, d, "R2 load");
  endtask

  task automatic do_op(input logic [1:0] sa, input logic [1:0] sb, input logic [2:0] f,
                       input logic [3:0] sh, input logic [1:0] dst, input string tag);
    logic [4:0] r;
    logic [3:0] other, keep;
    r = exp_alu(model[sa], model[sb], f);
    other = {2'b00, dst + 2'd1};
    keep = model[other[1:0]];
    @(negedge clk);
    op_valid = 1'b1; op_src_a = sa; op_src_b = sb; op_func = f; op_shift = sh; op_dst = dst;
    #1 check(op_ready == 1'b1, "R3 op_ready idle", op_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // keep valid high with other fields and issue a load: both must be ignored
    op_dst = other[1:0]; op_func = 3'd3; op_shift = 4'd1;
    ld_valid = 1'b1; ld_addr = other[1:0]; ld_data = ~keep;
    #1;
    check(busy == 1'b1, "R3 busy after accept", busy, 1);
    check(op_ready == 1'b0 && ld_ready == 1'b0, "R3 ready low while busy", {op_ready, ld_ready}, 0);
    check(shift_err == !is_onehot(sh), {"R9 shift_err ", tag}, shift_err, !is_onehot(sh));
    check(carry_out == r[4], {"R10 carry ", tag}, carry_out, r[4]);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; ld_valid = 1'b0;
    #1;
    check(busy == 1'b0, "R3 busy one cycle", busy, 0);
    check(shift_err == 1'b0, "R9 shift_err idle", shift_err, 0);
    model[dst] = exp_rot(r[3:0], sh);
    read_check(dst, model[dst], {"R10 writeback ", tag});
    read_check(other[1:0], keep, "R3 ignored while busy");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG_LIMIT) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(busy == 0 && carry_out == 0 && shift_err == 0, "R1 reset outputs",
          {busy, carry_out, shift_err}, 0);
    for (int i = 0; i < 4; i++) read_check(2'(i), 4'd0, "R1 reset register");

    // directed corners
    do_load(2'd0, 4'd9);
    do_load(2'd1, 4'd7);
    do_load(2'd2, 4'd15);
    do_load(2'd3, 4'd1);
    do_op(2'd0, 2'd1, 3'd0, 4'b0001, 2'd2, "R4 add overflow");
    do_op(2'd3, 2'd2, 3'd1, 4'b0001, 2'd3, "R5 sub borrow");
    do_load(2'd0, 4'd9);
    do_load(2'd1, 4'd9);
    do_op(2'd0, 2'd1, 3'd1, 4'b0001, 2'd2, "R5 sub equal");
    do_load(2'd2, 4'b1100);
    do_load(2'd3, 4'b1010);
    do_op(2'd2, 2'd3, 3'd2, 4'b0001, 2'd0, "R6 and");
    do_op(2'd2, 2'd3, 3'd3, 4'b0001, 2'd1, "R6 or");
    do_op(2'd2, 2'd3, 3'd4, 4'b0001, 2'd0, "R7 xor");
    do_op(2'd2, 2'd3, 3'd5, 4'b0001, 2'd1, "R7 xnor");
    do_op(2'd2, 2'd3, 3'd6, 4'b0001, 2'd0, "R4 code6 add");
    do_load(2'd0, 4'b0001);
    do_load(2'd1, 4'b0000);
    do_op(2'd0, 2'd1, 3'd0, 4'b0010, 2'd2, "R8 rotr1 is rotl3");
    check(model[2] == 4'b1000, "R8 rotr1 value", model[2], 8);
    do_op(2'd0, 2'd1, 3'd0, 4'b0100, 2'd2, "R8 rotr2");
    do_op(2'd0, 2'd1, 3'd0, 4'b1000, 2'd2, "R8 rotr3");
    do_op(2'd0, 2'd1, 3'd0, 4'b0000, 2'd3, "R9 zero control");
    do_op(2'd0, 2'd1, 3'd0, 4'b0110, 2'd3, "R9 two hot");

    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [3:0] sh;
      if ($urandom_range(0, 2) == 0)
        do_load(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)));
      sh = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15))
                                       : 4'(1 << $urandom_range(0, 3));
      do_op(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
            sh, 2'($urandom_range(0, 3)), "R4 R5 R6 R7 R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule